// File: doc/BRIEF.md
# Codec Register Command Port

This block gives host software a two-register window onto the control registers of an audio codec. One register is a command word and the other is a 16-bit data port. Software names a codec register with a 7-bit index and a 2-bit codec ID, and picks read or write with a single bit. Writing the command word launches the access. The block then carries the access to the codec over a request channel and reports its progress through two status bits in the command word. One bit shows that the port is busy. The other shows that read data has arrived in the data port.

For a write, software first loads the 16-bit value into the data port and then writes the command word with the operation bit cleared. For a read, software writes the command word with the operation bit set, polls until the valid bit is 1, and then reads the data port. The codec side is a valid/ready request channel. `req_valid` rises in the cycle after an accepted command. The channel holds address, ID, direction and write data stable until `req_ready` is sampled high. The codec applies back-pressure simply by holding `req_ready` low. For reads, the codec must present `rsp_rdata` in the same cycle that it raises `req_ready`. There is no separate response channel.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset, `cmd_status` and `data_port` read 0 and `req_valid` is 0.
- R2: In the command word, bits 6:0 hold the register index, bit 7 the operation (1 = read, 0 = write) and bits 11:10 the codec ID. `cmd_status` reads these fields back as last accepted. Its bits 15:12 read 0, and bits 9:8 of a written command word have no effect.
- R3: A command write (`host_we`=1, `host_sel`=0) accepted while the port is ready sets the busy bit (bit 9) and `req_valid` from the next cycle on. The same write clears the valid bit (bit 8).
- R4: Busy stays 1 until the cycle in which `req_valid` and `req_ready` are both 1, and it reads 0 from the next cycle on. With a codec that waits L cycles before raising ready, busy is therefore seen for L+1 cycles.
- R5: While a request waits for `req_ready`, `req_valid`, `req_addr`, `req_id`, `req_write` and `req_wdata` stay stable. Address, ID and direction equal the accepted command (`req_write` = 1 for a write), and `req_wdata` equals the data port.
- R6: A write access sends the value staged in the data port. After it completes, the valid bit stays 0 and the codec register holds that value.
- R7: A read access captures `rsp_rdata` on the handshake. From the next cycle on, the valid bit reads 1 and `data_port` shows the captured value.
- R8: A command write made while busy is ignored: the fields in `cmd_status` do not change and no extra request is issued.
- R9: A data port write (`host_sel`=1) made while busy is ignored: `data_port` and `req_wdata` keep their value.
- R10: A data port write made while ready shows up on `data_port` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Host register select: 0 = command word, 1 = data port |
| host_wdata | input | 16 | Host write data |
| cmd_status | output | 16 | Command word readback with busy (bit 9) and valid (bit 8) |
| data_port | output | 16 | Data port readback |
| req_valid | output | 1 | Codec request valid |
| req_ready | input | 1 | Codec request accepted (acknowledge) |
| req_write | output | 1 | Request direction: 1 = write, 0 = read |
| req_id | output | 2 | Codec ID of the request |
| req_addr | output | 7 | Codec register index of the request |
| req_wdata | output | 16 | Write data of the request |
| rsp_rdata | input | 16 | Read data, valid in the handshake cycle |

## Verification
Each host write lands on the register at the next rising edge. The bench drives host writes at falling edges and samples one falling edge later. It checks there that busy is 1 and valid is 0, and that data port loads are visible. A bench codec model holds ready low for a latency L that changes with every access. The bench counts the falling-edge samples that show busy, and expects exactly L+1 of them. The read data and the valid bit are then checked in the first sample after busy falls. The ignore cases are placed while the port is known to be busy: a codec latency of 4 keeps busy high across two further host writes.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  // Host register select encoding
  typedef enum logic {
    PORT_CMD  = 1'b0,
    PORT_DATA = 1'b1
  } port_sel_e;
endpackage

// File: rtl/ccp_cmd_ctrl.sv
module ccp_cmd_ctrl #(
  parameter int ADDR_W = 7,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rw_in,
  input  logic [ID_W-1:0]   id_in,
  input  logic              xfer_done,
  output logic              busy,
  output logic              valid,
  output logic              op_read,
  output logic [ADDR_W-1:0] addr,
  output logic [ID_W-1:0]   id
);
  logic accept;
  assign accept = cmd_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      valid   <= 1'b0;
      op_read <= 1'b0;
      addr    <= '0;
      id      <= '0;
    end else if (accept) begin
      addr    <= addr_in;
      op_read <= rw_in;
      id      <= id_in;
      busy    <= 1'b1;
      valid   <= 1'b0;
    end else if (busy && xfer_done) begin
      busy    <= 1'b0;
      valid   <= op_read;
    end
  end
endmodule

// File: rtl/ccp_data_port.sv
module ccp_data_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              hold,
  input  logic              capture,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)               q <= '0;
    else if (capture)         q <= rdata;
    else if (data_we && !hold) q <= wdata;
  end
endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port #(
  parameter int ADDR_W = 7,
  parameter int ID_W   = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] cmd_status,
  output logic [DATA_W-1:0] data_port,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ID_W-1:0]   req_id,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rsp_rdata
);
  import ccp_pkg::*;

  localparam int RW_BIT    = ADDR_W;
  localparam int VALID_BIT = ADDR_W + 1;
  localparam int BUSY_BIT  = ADDR_W + 2;
  localparam int ID_LSB    = ADDR_W + 3;

  logic              busy, valid, op_read, hs;
  logic [ADDR_W-1:0] addr;
  logic [ID_W-1:0]   id;
  logic [DATA_W-1:0] data_q;
  logic              cmd_we, data_we;

  assign cmd_we  = host_we && (host_sel == PORT_CMD);
  assign data_we = host_we && (host_sel == PORT_DATA);
  assign hs      = req_valid && req_ready;

  ccp_cmd_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .addr_in  (host_wdata[ADDR_W-1:0]),
    .rw_in    (host_wdata[RW_BIT]),
    .id_in    (host_wdata[ID_LSB +: ID_W]),
    .xfer_done(hs),
    .busy     (busy),
    .valid    (valid),
    .op_read  (op_read),
    .addr     (addr),
    .id       (id)
  );

  ccp_data_port #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_we(data_we),
    .hold   (busy),
    .capture(hs && op_read),
    .wdata  (host_wdata),
    .rdata  (rsp_rdata),
    .q      (data_q)
  );

  always_comb begin
    cmd_status                   = '0;
    cmd_status[ADDR_W-1:0]       = addr;
    cmd_status[RW_BIT]           = op_read;
    cmd_status[VALID_BIT]        = valid;
    cmd_status[BUSY_BIT]         = busy;
    cmd_status[ID_LSB +: ID_W]   = id;
  end

  assign data_port = data_q;
  assign req_valid = busy;
  assign req_write = !op_read;
  assign req_id    = id;
  assign req_addr  = addr;
  assign req_wdata = data_q;
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker #(
  parameter int ADDR_W = 7,
  parameter int ID_W   = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic              host_sel,
  input logic [DATA_W-1:0] cmd_status,
  input logic [DATA_W-1:0] data_port,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ID_W-1:0]   req_id,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rsp_rdata
);
  localparam int VALID_BIT = ADDR_W + 1;
  localparam int BUSY_BIT  = ADDR_W + 2;

  logic busy_s, hs_s, cmd_wr, data_wr;
  assign busy_s  = cmd_status[BUSY_BIT];
  assign hs_s    = req_valid && req_ready;
  assign cmd_wr  = host_we && (host_sel == ccp_pkg::PORT_CMD);
  assign data_wr = host_we && (host_sel == ccp_pkg::PORT_DATA);

  // R1: leaving reset the channel is idle
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !req_valid && cmd_status == '0);

  a_r3_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy_s |=> busy_s && req_valid && !cmd_status[VALID_BIT]);

  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_s && !hs_s |=> busy_s);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    hs_s |=> !busy_s);

  a_r5_stable_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_id)
      && $stable(req_write) && $stable(req_wdata));

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hs_s && !req_write |=> cmd_status[VALID_BIT] && data_port == $past(rsp_rdata));

  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy_s && !hs_s |=> $stable(cmd_status[ADDR_W:0]) && $stable(req_id));

  a_r9_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && busy_s && !hs_s |=> $stable(data_port));
endmodule

bind codec_cmd_port ccp_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_ccp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_sel  (host_sel),
  .cmd_status(cmd_status),
  .data_port (data_port),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_id    (req_id),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_codec_cmd_port.sv
`timescale 1ns/1ps
module test_codec_cmd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] cmd_status, data_port, req_wdata, rsp_rdata;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_id;
  logic [6:0]  req_addr;

  always #2 clk = ~clk;

  codec_cmd_port i_codec_cmd_port (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .cmd_status(cmd_status), .data_port(data_port),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata)
  );

  // Codec model: register file plus configurable ready latency
  logic [15:0] cmem [0:511];
  int          lat = 0;
  int          wcnt = 0;
  int          hs_count = 0;
  logic [6:0]  seen_addr;
  logic [1:0]  seen_id;
  logic        seen_wr;
  logic [15:0] seen_wdata;

  assign req_ready = req_valid && (wcnt >= lat);
  assign rsp_rdata = cmem[{req_id, req_addr}];

  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      if (req_write) cmem[{req_id, req_addr}] <= req_wdata;
      seen_addr  <= req_addr;
      seen_id    <= req_id;
      seen_wr    <= req_write;
      seen_wdata <= req_wdata;
      hs_count   <= hs_count + 1;
    end
    wcnt <= (req_valid && !req_ready) ? wcnt + 1 : 0;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int id, input int addr);
    pat = 16'(id * 16'h4001) ^ 16'(addr * 16'h0203) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] cmdw(input int id, input int addr, input logic rd, input logic [5:0] junk);
    cmdw = {junk[5:2], 2'(id), junk[1:0], rd, 7'(addr)};
  endfunction

  task automatic host_write(input logic sel, input logic [15:0] d);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_idle(output int t);
    t = 0;
    while (cmd_status[9] && t < 50) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic do_write(input int id, input int addr, input int l);
    int t;
    logic [15:0] d;
    d = pat(id, addr);
    lat = l;
    host_write(1'b1, d);
    chk("R10 data port load", data_port, d);
    host_write(1'b0, cmdw(id, addr, 1'b0, 6'(addr ^ (id << 3))));
    chk("R3 busy set", cmd_status[9], 1);
    chk("R3 valid cleared", cmd_status[8], 0);
    chk("R2 fields", cmd_status & 16'hFCFF, {4'h0, 2'(id), 2'b00, 1'b0, 7'(addr)});
    wait_idle(t);
    chk("R4 busy length", t, l + 1);
    chk("R5 request fields", {seen_wr, seen_id, seen_addr}, {1'b1, 2'(id), 7'(addr)});
    chk("R6 write data", seen_wdata, d);
    chk("R6 valid stays low", cmd_status[8], 0);
  endtask

  task automatic do_read(input int id, input int addr, input int l);
    int t;
    lat = l;
    host_write(1'b0, cmdw(id, addr, 1'b1, 6'(~addr)));
    chk("R3 busy set", cmd_status[9], 1);
    chk("R3 valid cleared", cmd_status[8], 0);
    chk("R2 fields", cmd_status & 16'hFCFF, {4'h0, 2'(id), 2'b00, 1'b1, 7'(addr)});
    wait_idle(t);
    chk("R4 busy length", t, l + 1);
    chk("R5 request fields", {seen_wr, seen_id, seen_addr}, {1'b0, 2'(id), 7'(addr)});
    chk("R7 valid set", cmd_status[8], 1);
    chk("R7 read data", data_port, pat(id, addr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t, hc;
    for (int i = 0; i < 512; i++) cmem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 status reset", cmd_status, 0);
    chk("R1 data reset", data_port, 0);
    chk("R1 req_valid reset", req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: write every register of every codec, then read all back
    for (int id = 0; id < 4; id++)
      for (int a = 0; a < 128; a++)
        do_write(id, a, (id + a) % 4);
    for (int id = 0; id < 4; id++)
      for (int a = 0; a < 128; a++)
        do_read(id, a, (a + 2 * id) % 4);

    // R8: command written while busy is ignored
    hc = hs_count;
    lat = 4;
    host_write(1'b0, cmdw(1, 5, 1'b1, 6'h0));
    host_write(1'b0, cmdw(2, 9, 1'b0, 6'h0));
    chk("R8 fields unchanged", cmd_status & 16'h0CFF, {4'h0, 2'd1, 2'b00, 1'b1, 7'd5});
    wait_idle(t);
    chk("R8 single request", hs_count - hc, 1);
    chk("R8 request addr", {seen_id, seen_addr}, {2'd1, 7'd5});
    chk("R8 read data", data_port, pat(1, 5));

    // R9: data write while busy is ignored
    lat = 4;
    host_write(1'b1, 16'h1234);
    host_write(1'b0, cmdw(3, 77, 1'b0, 6'h0));
    host_write(1'b1, 16'hBEEF);
    chk("R9 data port kept", data_port, 16'h1234);
    chk("R9 req_wdata kept", req_wdata, 16'h1234);
    wait_idle(t);
    chk("R9 codec got staged data", seen_wdata, 16'h1234);
    chk("R6 codec register", cmem[{2'd3, 7'd77}], 16'h1234);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule